// File: doc/BRIEF.md
# Timer Compare Interrupt Unit

This block holds a compare value that software writes. On every clock it checks that value against a free-running count value that arrives on an input. When the two are equal, a timer-pending flag is set. The flag is sticky and stays set until the next write to the compare value; there is no separate acknowledge. The flag appears as a status bit and is ORed with one hardware interrupt input to drive a single interrupt line.

The compare value can be read back at any time for diagnostics. It changes only when software writes it. The logic that increments the count lives outside the block. Any vectoring or prioritising of the interrupt line also happens outside the block.

Top module: `tcmp_unit`

## Requirements
- R1: While rst_n is low, and after rst_n is released, the compare readback is zero and the pending flag is zero.
- R2: A clock edge with cmp_wr_en high loads cmp_wr_data into the compare register. The new value appears on cmp_rd_data from that edge on.
- R3: A clock edge with cmp_wr_en low leaves cmp_rd_data unchanged, whatever count_val is.
- R4: A clock edge with cmp_wr_en low and count_val equal to cmp_rd_data sets timer_pending from that edge on.
- R5: Once set, timer_pending stays high across edges where cmp_wr_en is low, even after count_val moves past the compare value.
- R6: Any clock edge with cmp_wr_en high clears timer_pending, including a write of the value already held.
- R7: When a write and an equality match fall on the same edge, the write wins and timer_pending is low after that edge.
- R8: irq_out equals timer_pending OR hw_irq_in at all times, with no register in the path from hw_irq_in.
- R9: With timer_pending low, a clock edge with cmp_wr_en low and count_val different from cmp_rd_data keeps timer_pending low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_val | input | DATA_W | Current free-running count value |
| cmp_wr_en | input | 1 | Software write strobe for the compare register |
| cmp_wr_data | input | DATA_W | Value to write into the compare register |
| cmp_rd_data | output | DATA_W | Diagnostic readback of the compare register |
| hw_irq_in | input | 1 | Hardware interrupt source that shares the output line |
| timer_pending | output | 1 | Sticky timer-interrupt status bit |
| irq_out | output | 1 | Timer pending ORed with hw_irq_in |

## Verification
The assertions assume that count_val, cmp_wr_en and cmp_wr_data are settled at every rising edge. They also assume that hw_irq_in may change at any time, so the output-line check is written as a combinational relation. The stimulus changes every input only on the falling edge. It leaves count_val away from zero while reset is released, so that the first match comes from a vector the bench chose. The vectors include a rewrite of the unchanged value, a match against the old value during a write, and a match against the all-ones compare value.

// File: rtl/tcmp_pkg.sv
// Package: shared constants for the timer compare unit.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package tcmp_pkg;
    // Default width of the count and compare values.
    localparam int TCMP_DEFAULT_W = 32;

    // Reset value of the compare register.
    function automatic logic [TCMP_DEFAULT_W-1:0] tcmp_reset_value();
        return '0;
    endfunction
endpackage

// File: rtl/tcmp_cmp_reg.sv
// Compare register: holds the software-written compare value.
// Assumes: wr_en and wr_data are stable at the rising edge, and the reset is
// synchronous and active low.
module tcmp_cmp_reg #(
    parameter int DATA_W = tcmp_pkg::TCMP_DEFAULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value_q
);
    localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(tcmp_pkg::tcmp_reset_value());

    // Load on a write; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= RESET_VAL;
        end else if (wr_en) begin
            value_q <= wr_data;
        end
    end
endmodule

// File: rtl/tcmp_eq.sv
// Equality detector: compares two words as a set of slices and reduces the
// slice results.
// Assumes: DATA_W >= 1. SLICE_W need not divide DATA_W.
module tcmp_eq #(
    parameter int DATA_W  = tcmp_pkg::TCMP_DEFAULT_W,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              equal
);
    localparam int NSLICE = (DATA_W + SLICE_W - 1) / SLICE_W;

    logic [NSLICE-1:0] slice_eq;

    genvar gi;
    generate
        for (gi = 0; gi < NSLICE; gi++) begin : g_slice
            localparam int LO = gi * SLICE_W;
            localparam int HI = ((LO + SLICE_W) > DATA_W) ? DATA_W - 1 : LO + SLICE_W - 1;
            // Compare one slice.
            always_comb begin
                slice_eq[gi] = (a[HI:LO] == b[HI:LO]);
            end
        end
    endgenerate

    // Reduce the slice results.
    always_comb begin
        equal = &slice_eq;
    end
endmodule

// File: rtl/tcmp_pend.sv
// Pending flag: set on a match, cleared only by a compare write.
// Assumes: match and clr come from settled logic. clr takes priority over match.
module tcmp_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    output logic pend_q
);
    // A write clears the flag, a match sets it, and otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (match) begin
            pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tcmp_unit.sv
// Timer compare unit: compare register, equality detector and sticky
// pending flag, with one shared interrupt output.
// Assumes: count_val comes from an external free-running counter in the
// same clock domain, and the reset is synchronous and active low.
module tcmp_unit #(
    parameter int DATA_W = tcmp_pkg::TCMP_DEFAULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] count_val,
    input  logic              cmp_wr_en,
    input  logic [DATA_W-1:0] cmp_wr_data,
    output logic [DATA_W-1:0] cmp_rd_data,
    input  logic              hw_irq_in,
    output logic              timer_pending,
    output logic              irq_out
);
    logic [DATA_W-1:0] cmp_q;
    logic              hit;

    tcmp_cmp_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .value_q (cmp_q)
    );

    tcmp_eq #(.DATA_W(DATA_W)) u_eq (
        .a     (count_val),
        .b     (cmp_q),
        .equal (hit)
    );

    tcmp_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (hit),
        .clr    (cmp_wr_en),
        .pend_q (timer_pending)
    );

    // Drive the readback and merge the two interrupt sources.
    always_comb begin
        cmp_rd_data = cmp_q;
        irq_out     = timer_pending | hw_irq_in;
    end
endmodule

// File: rtl/tcmp_chk.sv
// Checker for tcmp_unit, attached through bind. It observes the ports only.
// Assumes: inputs are stable at rising edges.
module tcmp_chk #(
    parameter int DATA_W = tcmp_pkg::TCMP_DEFAULT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] count_val,
    input logic              cmp_wr_en,
    input logic [DATA_W-1:0] cmp_wr_data,
    input logic [DATA_W-1:0] cmp_rd_data,
    input logic              hw_irq_in,
    input logic              timer_pending,
    input logic              irq_out
);
    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_en |=> (cmp_rd_data == $past(cmp_wr_data)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_wr_en |=> $stable(cmp_rd_data));

    // R4
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr_en && (count_val == cmp_rd_data)) |=> timer_pending);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr_en && timer_pending) |=> timer_pending);

    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_en |=> !timer_pending);

    // R7
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_en && (count_val == cmp_rd_data)) |=> !timer_pending);

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr_en && !timer_pending && (count_val != cmp_rd_data)) |=> !timer_pending);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!timer_pending && (cmp_rd_data == '0)));

    // R8
    always_comb begin
        irq_merge_chk: assert (irq_out == (timer_pending | hw_irq_in));
    end
endmodule

bind tcmp_unit tcmp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_val     (count_val),
    .cmp_wr_en     (cmp_wr_en),
    .cmp_wr_data   (cmp_wr_data),
    .cmp_rd_data   (cmp_rd_data),
    .hw_irq_in     (hw_irq_in),
    .timer_pending (timer_pending),
    .irq_out       (irq_out)
);

// File: tb/tcmp_unit_tb.sv
module tcmp_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NVEC = 14;
    // Vector layout: {wr, data, count, hw, exp_rd, exp_pend, exp_irq}
    localparam logic [99:0] VECS [0:NVEC-1] = '{
        {1'b0, 32'h0,        32'h5,        1'b0, 32'h0,        1'b0, 1'b0}, // R9
        {1'b1, 32'h10,       32'h6,        1'b0, 32'h10,       1'b0, 1'b0}, // R2
        {1'b0, 32'h99,       32'hF,        1'b0, 32'h10,       1'b0, 1'b0}, // R3 R9
        {1'b0, 32'h0,        32'h10,       1'b0, 32'h10,       1'b1, 1'b1}, // R4
        {1'b0, 32'h0,        32'h11,       1'b0, 32'h10,       1'b1, 1'b1}, // R5
        {1'b0, 32'h0,        32'h12,       1'b1, 32'h10,       1'b1, 1'b1}, // R5 R8
        {1'b1, 32'h10,       32'h13,       1'b0, 32'h10,       1'b0, 1'b0}, // R6
        {1'b0, 32'h0,        32'h13,       1'b1, 32'h10,       1'b0, 1'b1}, // R8
        {1'b0, 32'h0,        32'h10,       1'b0, 32'h10,       1'b1, 1'b1}, // R4
        {1'b1, 32'h20,       32'h10,       1'b0, 32'h20,       1'b0, 1'b0}, // R7
        {1'b1, 32'h30,       32'h20,       1'b0, 32'h30,       1'b0, 1'b0}, // R7
        {1'b0, 32'h0,        32'h30,       1'b0, 32'h30,       1'b1, 1'b1}, // R4
        {1'b1, 32'hFFFFFFFF, 32'h0,        1'b0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R6
        {1'b0, 32'h0,        32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b1}  // R4
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_val = '0;
    logic         cmp_wr_en = 1'b0;
    logic [W-1:0] cmp_wr_data = '0;
    logic [W-1:0] cmp_rd_data;
    logic         hw_irq_in = 1'b0;
    logic         timer_pending;
    logic         irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    tcmp_unit #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_val(count_val),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cmp_rd_data(cmp_rd_data), .hw_irq_in(hw_irq_in),
        .timer_pending(timer_pending), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        count_val = 32'h5;
        repeat (3) edge_step();
        check("R1 rd", cmp_rd_data, '0);
        check("R1 pend", {31'b0, timer_pending}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [99:0] v;
            v = VECS[i];
            @(negedge clk);
            cmp_wr_en   = v[99];
            cmp_wr_data = v[98:67];
            count_val   = v[66:35];
            hw_irq_in   = v[34];
            edge_step();
            check($sformatf("R2/R3 rd vec%0d", i), cmp_rd_data, v[33:2]);
            check($sformatf("R4/R5/R6/R7/R9 pend vec%0d", i), {31'b0, timer_pending}, {31'b0, v[1]});
            check($sformatf("R8 irq vec%0d", i), {31'b0, irq_out}, {31'b0, v[0]});
        end

        // R8: the hw input reaches irq_out with no clock edge in between.
        @(negedge clk);
        cmp_wr_en = 1'b1; cmp_wr_data = 32'h100; count_val = 32'h1; hw_irq_in = 1'b0;
        edge_step();
        #1 hw_irq_in = 1'b1;
        #1 check("R8 comb high", {31'b0, irq_out}, 32'h1);
        hw_irq_in = 1'b0;
        #1 check("R8 comb low", {31'b0, irq_out}, 32'h0);

        // R5: the flag stays set over many count values that do not match.
        @(negedge clk);
        cmp_wr_en = 1'b0; count_val = 32'h100;
        edge_step();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            count_val = 32'h200 + k;
            edge_step();
        end
        check("R5 long hold", {31'b0, timer_pending}, 32'h1);
        check("R3 long hold", cmp_rd_data, 32'h100);

        // R1: a reset in the middle of operation clears both the flag and the register.
        @(negedge clk);
        rst_n = 1'b0; count_val = 32'h7;
        edge_step();
        check("R1 mid rd", cmp_rd_data, '0);
        check("R1 mid pend", {31'b0, timer_pending}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        edge_step();
        check("R9 after reset", {31'b0, timer_pending}, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule